// File: doc/BRIEF.md
# Fractional Baud Clock Divider

This block turns a fast system clock into a one-cycle enable pulse for a serial interface. The target rate need not divide the system clock exactly. Each tick period is an integer number of system clocks. A 4-bit fractional correction, counted in sixteenths of a clock, is gathered in an accumulator. Whenever that accumulator wraps, the current period is made one clock longer. Over many periods the average rate therefore lands within a sixteenth of a clock of the programmed value.

The divider has two modes:
- **UART mode.** The tick is the 16x oversampling enable for an asynchronous receiver and transmitter. One bit time is sixteen ticks. The correction is added once per bit time.
- **Infrared mode.** The tick is a reference clock enable. The correction is added on every period. The count field is only 4 bits wide, and a value of zero is rejected.

Settings are loaded through a single write strobe. A write restarts the period from a clean state. An illegal setting raises a sticky error and halts the ticks until a legal setting is written.

Top module: `baud_frac_div`

## Requirements
- R1: After reset, `tick` and `cfg_err` are 0, and no tick appears until a configuration write.
- R2: Only bits 7:4 of `cfg_corr` carry the fractional correction f (0 to 15 sixteenths). Bits 3:0 have no effect.
- R3: In UART mode (`cfg_ir`=0) with count c, the ticks of every 256 consecutive periods after a write span exactly 256*(c+1)+f system clocks.
- R4: In UART mode every period is c+1 or c+2 clocks. Only the period ending each sixteenth tick (ticks 16, 32, ...) may be the long one.
- R5: In infrared mode (`cfg_ir`=1) only `cfg_count` bits 3:0 form the count c. Each period is c+1 or c+2 clocks. Every 16 consecutive periods after a write span exactly 16*(c+1)+f clocks.
- R6: An infrared-mode write whose count bits 3:0 are zero sets `cfg_err` in the next cycle. The error stays set, with `tick` held low, until the next write.
- R7: A write of a legal setting clears `cfg_err` and restarts tick generation.
- R8: A write restarts the period. The first tick is asserted c+1 cycles after the write edge, even when the write coincides with a tick.
- R9: When c is at least 1, `tick` is high for exactly one cycle per period and never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for the three configuration inputs |
| cfg_ir | input | 1 | Mode select: 0 selects UART oversampling, 1 selects infrared reference |
| cfg_count | input | CNT_W | Integer period count c (period is c+1 clocks) |
| cfg_corr | input | 8 | Correction register; bits 7:4 hold the fraction |
| tick | output | 1 | One-cycle rate enable |
| cfg_err | output | 1 | Sticky illegal-setting flag |

## Verification
Two events can land on the same clock edge: a configuration write and the end of a period, which may be a stretched one. The write must win. The counter and the accumulator must restart cleanly, so no extra, short or doubled tick appears.

The bench provokes this case by waiting for a visible tick and asserting the write strobe in that same cycle. It then measures the first new period, which must be exactly c+1 clocks, and the total span of the following periods against the exact fractional sum.

Random counts and corrections, with random junk in the ignored bits, are mixed with directed zero-count, full-fraction and zero-fraction cases in both modes.

// File: rtl/baud_frac_pkg.sv
package baud_frac_pkg;

    localparam int FRAC_W = 4;
    localparam int SUB_N  = 16;
    localparam int IR_W   = 4;

    typedef enum logic {
        MODE_UART = 1'b0,
        MODE_IR   = 1'b1
    } baud_mode_e;

    typedef struct packed {
        baud_mode_e        mode;
        logic [FRAC_W-1:0] frac;
    } baud_ctl_t;

    function automatic logic [FRAC_W-1:0] corr_field(input logic [7:0] corr);
        return corr[7:4];
    endfunction

    function automatic logic ir_count_zero(input logic [IR_W-1:0] cnt_lo);
        return cnt_lo == '0;
    endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
    import baud_frac_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             ir_in,
    input  logic [CNT_W-1:0] count_in,
    input  logic [7:0]       corr_in,
    output baud_ctl_t        ctl,
    output logic [CNT_W-1:0] count_eff,
    output logic             running,
    output logic             err
);

    logic [CNT_W-1:0] count_q;
    logic             illegal_w;

    assign illegal_w = ir_in && ir_count_zero(count_in[IR_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '{mode: MODE_UART, frac: '0};
            count_q <= '0;
            running <= 1'b0;
            err     <= 1'b0;
        end else if (we) begin
            ctl.mode <= ir_in ? MODE_IR : MODE_UART;
            ctl.frac <= corr_field(corr_in);
            count_q  <= count_in;
            running  <= !illegal_w;
            err      <= illegal_w;
        end
    end

    generate
        if (CNT_W > IR_W) begin : g_mask
            always_comb begin
                if (ctl.mode == MODE_IR) count_eff = {{(CNT_W-IR_W){1'b0}}, count_q[IR_W-1:0]};
                else                     count_eff = count_q;
            end
        end else begin : g_nomask
            assign count_eff = count_q;
        end
    endgenerate

    AST_ERR_ON_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        we && ir_in && count_in[IR_W-1:0] == '0 |=> err);                 // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err && !we |=> err);                                               // R6
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        we && !(ir_in && count_in[IR_W-1:0] == '0) |=> !err && running);   // R7

endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc
    import baud_frac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              tick,
    input  baud_ctl_t         ctl,
    output logic              stretch
);

    localparam int SUB_W = $clog2(SUB_N);

    logic [FRAC_W-1:0] acc;
    logic [SUB_W-1:0]  sub;
    logic              add_now;
    logic [FRAC_W:0]   sum;

    assign add_now = (ctl.mode == MODE_IR) || (sub == SUB_W'(SUB_N - 1));
    assign sum     = {1'b0, acc} + {1'b0, ctl.frac};
    assign stretch = add_now && sum[FRAC_W];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
            sub <= '0;
        end else if (tick) begin
            sub <= sub + 1'b1;
            if (add_now) acc <= sum[FRAC_W-1:0];
        end
    end

    AST_UART_STRETCH_SLOT: assert property (@(posedge clk) disable iff (rst)
        stretch && ctl.mode == MODE_UART |-> sub == SUB_W'(SUB_N - 1));    // R4
    AST_ZERO_FRAC_NO_STRETCH: assert property (@(posedge clk) disable iff (rst)
        ctl.frac == '0 |-> !stretch);                                      // R3

endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt #(
    parameter int LIM_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [LIM_W-1:0] limit,
    output logic             tick
);

    logic [LIM_W-1:0] cnt;

    assign tick = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) cnt <= '0;
        else if (cnt >= limit)    cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt <= limit);                                             // R5
    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
        clear |=> cnt == '0);                                              // R8

endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div
    import baud_frac_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_ir,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [7:0]       cfg_corr,
    output logic             tick,
    output logic             cfg_err
);

    localparam int LIM_W = CNT_W + 1;

    baud_ctl_t        ctl;
    logic [CNT_W-1:0] count_eff;
    logic             running;
    logic             stretch;
    logic [LIM_W-1:0] limit;

    baud_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .ir_in     (cfg_ir),
        .count_in  (cfg_count),
        .corr_in   (cfg_corr),
        .ctl       (ctl),
        .count_eff (count_eff),
        .running   (running),
        .err       (cfg_err)
    );

    baud_frac_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .clear   (cfg_we),
        .tick    (tick),
        .ctl     (ctl),
        .stretch (stretch)
    );

    assign limit = {1'b0, count_eff} + LIM_W'(stretch);

    baud_period_cnt #(.LIM_W(LIM_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (cfg_we),
        .run   (running),
        .limit (limit),
        .tick  (tick)
    );

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !tick);                                                // R6
    AST_SINGLE_TICK: assert property (@(posedge clk) disable iff (rst)
        tick && count_eff != '0 && !cfg_we |=> !tick);                     // R9
    AST_NO_TICK_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        cfg_we && (cfg_ir ? cfg_count[IR_W-1:0] : cfg_count) != '0 |=> !tick); // R8

endmodule

// File: tb/baud_frac_div_bench.sv
module baud_frac_div_bench;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic             cfg_ir = 1'b0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic [7:0]       cfg_corr = '0;
    logic             tick;
    logic             cfg_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    baud_frac_div #(.CNT_W(CNT_W)) u_baud_frac_div (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_ir    (cfg_ir),
        .cfg_count (cfg_count),
        .cfg_corr  (cfg_corr),
        .tick      (tick),
        .cfg_err   (cfg_err)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int base_period(input bit ir, input int cnt);
        return ir ? (cnt & 15) + 1 : cnt + 1;
    endfunction

    function automatic longint exp_span(input bit ir, input int cnt, input int corr, input int nt);
        int f = (corr >> 4) & 15;
        int grp = ir ? 16 : 256;
        return longint'(nt) * base_period(ir, cnt) + longint'(f) * (nt / grp);
    endfunction

    task automatic do_write(input bit ir, input int cnt, input int corr);
        cfg_we    = 1'b1;
        cfg_ir    = ir;
        cfg_count = CNT_W'(cnt);
        cfg_corr  = 8'(corr);
        @(posedge clk);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic run_case(input bit ir, input int cnt, input int corr, input int nt, input bit align);
        int b = base_period(ir, cnt);
        int f = (corr >> 4) & 15;
        int last = 0, nticks = 0, nlong = 0, i = 1;
        bit bad_len = 0, bad_slot = 0, first_ok = 1;
        if (align) begin
            int w = 0;
            while (!tick && w < 600) begin @(negedge clk); w++; end
            check(tick == 1'b1, "R8 align", tick, 1);
        end
        do_write(ir, cnt, corr);
        check(cfg_err == 1'b0, "R7", cfg_err, 0);
        while (nticks < nt && i < 80000) begin
            if (tick) begin
                int len = i - last;
                nticks++;
                if (nticks == 1 && len != b) first_ok = 0;
                if (len != b && len != b + 1) bad_len = 1;
                if (len == b + 1) begin
                    nlong++;
                    if (!ir && (nticks % 16) != 0) bad_slot = 1;
                end
                last = i;
            end
            @(negedge clk);
            i++;
        end
        check(first_ok, "R8 first period", first_ok, 1);
        check(!bad_len, ir ? "R5 period length" : "R4 period length", bad_len, 0);
        if (!ir) check(!bad_slot, "R4 stretch slot", bad_slot, 0);
        check(last == exp_span(ir, cnt, corr, nt), ir ? "R5 span" : "R3 span", last, exp_span(ir, cnt, corr, nt));
        check(nlong == f * (nt / (ir ? 16 : 256)), "R2 fraction count", nlong, f * (nt / (ir ? 16 : 256)));
    endtask

    task automatic single_tick_scan(input int n);
        bit prev = 0, dbl = 0;
        for (int k = 0; k < n; k++) begin
            if (prev && tick) dbl = 1;
            prev = tick;
            @(negedge clk);
        end
        check(!dbl, "R9 single-cycle tick", dbl, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        begin
            bit any = 0;
            for (int k = 0; k < 30; k++) begin
                if (tick || cfg_err) any = 1;
                @(negedge clk);
            end
            check(!any, "R1 reset idle", any, 0);
        end

        // directed: UART modes
        run_case(1'b0, 3, 8'hF0, 256, 0);   // R3 full fraction
        run_case(1'b0, 2, 8'h0F, 256, 0);   // R2 low bits ignored, zero fraction
        run_case(1'b0, 0, 8'h70, 256, 0);   // R3 count zero
        run_case(1'b0, 5, 8'h93, 256, 1);   // R8 write on a tick
        // directed: IR modes
        run_case(1'b1, 9, 8'h50, 64, 0);    // R5
        run_case(1'b1, 8'h37, 8'hF0, 64, 1); // R5 upper count bits ignored
        single_tick_scan(200);              // R9

        // R6 illegal zero count, then R7 recovery
        do_write(1'b1, 8'h40, 8'h30);
        begin
            bit ok = 1;
            for (int k = 0; k < 60; k++) begin
                if (!cfg_err || tick) ok = 0;
                @(negedge clk);
            end
            check(ok, "R6 sticky error and no ticks", ok, 1);
        end
        run_case(1'b1, 1, 8'h80, 32, 0);    // R7

        // random mix
        for (int n = 0; n < 12; n++) begin
            bit ir = n[0];
            int cnt = ir ? 1 + ($urandom % 15) : $urandom % 8;
            int corr = $urandom % 256;
            run_case(ir, cnt, corr, ir ? 48 : 256, bit'($urandom % 2));
            if (cnt > 0) single_tick_scan(60);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule